// File: doc/BRIEF.md
# Fractional Clock Rate Generator

This block turns a stream of source clock-enable pulses into a slower stream of single-cycle enable pulses. The slowdown is the ratio 1 + MULT/256. It never stretches or shortens a gap by a fraction of a cycle. Instead it removes whole source pulses, spread as evenly as possible over time. A phase accumulator that runs modulo 256 + MULT decides which pulses to remove. Over every span of 256 + MULT source pulses, counted from phase zero, exactly MULT pulses are dropped and 256 are passed.

One of three source enables is chosen through a select input. The three sources are an internal oscillator, the main clock and a PLL clock. Software sets the numerator and the denominator field through a small write/read register port. Fractional operation needs a denominator field of 0xFF, which stands for 256. With any other value the block passes every pulse through unchanged. It also records the misuse in a sticky error flag. Writing either field restarts the phase. A change of source restarts the phase too, and it discards the first pulse seen after the change. A free-running counter of emitted pulses is provided so that the rate can be observed.

Top module: `frac_rate_gen`

## Requirements
- R1: After a synchronous reset, `tick_out` is 0, `tick_count` is 0 and `cfg_err` is 0. Reading address 0 (numerator) returns 0, and reading address 1 (denominator field) returns 0.
- R2: `src_sel` = 0 selects `src_osc_en`, 1 selects `src_main_en` and 2 selects `src_pll_en`. The value 3 selects nothing. Pulses on inputs that are not selected never produce a tick.
- R3: With the denominator field at 0xFF and numerator 0, every selected pulse gives `tick_out` = 1 exactly one clock later.
- R4: With the denominator field at 0xFF, the k-th selected pulse after phase zero (k = 1, 2, ...) is removed exactly when floor(k*MULT/(256+MULT)) > floor((k-1)*MULT/(256+MULT)). A pulse that is not removed raises `tick_out` for one clock, in the cycle after the pulse.
- R5: With the denominator field at 0xFF, any 256+MULT consecutive selected pulses that start at phase zero give exactly 256 ticks.
- R6: While the denominator field is not 0xFF, every selected pulse that is not discarded by a source change produces a tick one clock later.
- R7: `cfg_err` goes to 1 one clock after a selected pulse arrives while the denominator field is not 0xFF. It then stays 1 until reset, even after the field is corrected.
- R8: A write to either field (`cfg_wr` = 1, `cfg_addr` 0 = numerator, 1 = denominator field) returns the phase to zero, so counting for R4 restarts at k = 1.
- R9: When `src_sel` differs from its value in the previous clock, the phase returns to zero. The first selected pulse in that cycle or later produces no tick, and it does not advance the phase.
- R10: `tick_count` increases by exactly one in the clock where `tick_out` is 1 and otherwise holds. It wraps modulo 2^CNT_W.
- R11: `cfg_rdata` shows, without a clock delay, the numerator when `cfg_addr` is 0 and the denominator field when `cfg_addr` is 1. Both are the last values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_osc_en | input | 1 | Oscillator source pulse |
| src_main_en | input | 1 | Main clock source pulse |
| src_pll_en | input | 1 | PLL source pulse |
| src_sel | input | 2 | Source choice: 0 oscillator, 1 main, 2 PLL, 3 none |
| cfg_wr | input | 1 | Field write strobe |
| cfg_addr | input | 1 | Field address: 0 numerator, 1 denominator field |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the field at `cfg_addr` |
| tick_out | output | 1 | Reduced-rate single-cycle enable |
| tick_count | output | CNT_W | Count of emitted ticks |
| cfg_err | output | 1 | Sticky unsupported-denominator flag |

## Verification
The assertions assume that `src_sel` is stable through reset. They also assume that a field write never lands in the same cycle as a selected source pulse, because the phase cleared by the write would otherwise compete with that pulse's phase step. The stimulus holds `src_sel` at 0 whenever reset is applied. It puts every register write in a cycle of its own with all source enables low. Selected pulses go both back-to-back and with gaps, so removal decisions are checked at full source rate and at sparse rate.

// File: rtl/frg_pkg.sv
package frg_pkg;

    localparam int FRAC_W  = 8;
    localparam int PHASE_W = FRAC_W + 1;
    localparam int NUM_SRC = 3;
    localparam int SEL_W   = $clog2(NUM_SRC + 1);

    localparam logic [FRAC_W-1:0] DIV_FULL = '1;

    typedef enum logic [SEL_W-1:0] {
        SRC_OSC  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_NONE = 2'd3
    } src_sel_e;

    typedef enum logic {
        FIELD_MULT = 1'b0,
        FIELD_DIV  = 1'b1
    } field_e;

    typedef struct packed {
        logic [FRAC_W-1:0] mult;
        logic [FRAC_W-1:0] div;
    } frac_cfg_t;

    typedef struct packed {
        logic pulse;
        logic pass;
        logic supported;
    } step_t;

    function automatic logic [PHASE_W-1:0] phase_modulus(input logic [FRAC_W-1:0] m);
        return {1'b1, {FRAC_W{1'b0}}} + PHASE_W'(m);
    endfunction

    function automatic logic div_supported(input logic [FRAC_W-1:0] d);
        return d == DIV_FULL;
    endfunction

endpackage

// File: rtl/frg_src_mux.sv
module frg_src_mux #(
    parameter int N   = 3,
    parameter int S_W = 2
) (
    input  logic [N-1:0]   src_vec,
    input  logic [S_W-1:0] sel,
    output logic           pulse
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_src
        localparam logic [S_W-1:0] CODE = S_W'(i);
        assign hit[i] = src_vec[i] && (sel == CODE);
    end

    assign pulse = |hit;
endmodule

// File: rtl/frg_cfg_regs.sv
module frg_cfg_regs
    import frg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              addr,
    input  logic [FRAC_W-1:0] wdata,
    output logic [FRAC_W-1:0] rdata,
    output frac_cfg_t         cfg,
    output logic              touched
);
    frac_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            if (field_e'(addr) == FIELD_DIV) cfg_q.div  <= wdata;
            else                            cfg_q.mult <= wdata;
        end
    end

    always_comb begin
        if (field_e'(addr) == FIELD_DIV) rdata = cfg_q.div;
        else                             rdata = cfg_q.mult;
    end

    assign cfg     = cfg_q;
    assign touched = wr;
endmodule

// File: rtl/frg_phase_acc.sv
module frg_phase_acc
    import frg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pulse,
    input  logic [SEL_W-1:0]   sel,
    input  frac_cfg_t          cfg,
    input  logic               clr,
    output step_t              step,
    output logic               drop_eff,
    output logic [PHASE_W-1:0] phase
);
    logic [PHASE_W-1:0] phase_q, phase_d, modulus;
    logic [PHASE_W:0]   sum;
    logic               wrap, supported, switch_now;
    logic               drop_q, drop_d;
    logic [SEL_W-1:0]   sel_q;

    always_comb begin
        modulus    = phase_modulus(cfg.mult);
        sum        = {1'b0, phase_q} + {2'b00, cfg.mult};
        wrap       = sum >= {1'b0, modulus};
        supported  = div_supported(cfg.div);
        switch_now = sel != sel_q;
        drop_eff   = switch_now || drop_q;

        step.pulse     = pulse;
        step.supported = supported;
        if (!pulse || drop_eff) step.pass = 1'b0;
        else if (!supported)    step.pass = 1'b1;
        else                    step.pass = !wrap;

        if (clr || switch_now || !supported)
            phase_d = '0;
        else if (pulse && !drop_eff)
            phase_d = wrap ? PHASE_W'(sum - {1'b0, modulus}) : sum[PHASE_W-1:0];
        else
            phase_d = phase_q;

        if (pulse && drop_eff) drop_d = 1'b0;
        else if (switch_now)   drop_d = 1'b1;
        else                   drop_d = drop_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            drop_q  <= 1'b0;
            sel_q   <= SRC_OSC;
        end else begin
            phase_q <= phase_d;
            drop_q  <= drop_d;
            sel_q   <= sel;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/frg_tick_out.sv
module frg_tick_out
    import frg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    output logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tick  <= 1'b0;
            count <= '0;
            err   <= 1'b0;
        end else begin
            tick <= step.pass;
            if (step.pass) count <= count + 1'b1;
            if (step.pulse && !step.supported) err <= 1'b1;
        end
    end
endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen
    import frg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_osc_en,
    input  logic             src_main_en,
    input  logic             src_pll_en,
    input  logic [1:0]       src_sel,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output logic             tick_out,
    output logic [CNT_W-1:0] tick_count,
    output logic             cfg_err
);
    logic [NUM_SRC-1:0] src_vec;
    logic               sel_pulse, touched, drop_eff;
    frac_cfg_t          cfg;
    step_t              step;
    logic [PHASE_W-1:0] phase_q;
    logic [FRAC_W-1:0]  cur_mult, cur_div;

    assign src_vec  = {src_pll_en, src_main_en, src_osc_en};
    assign cur_mult = cfg.mult;
    assign cur_div  = cfg.div;

    frg_src_mux #(.N(NUM_SRC), .S_W(SEL_W)) u_mux (
        .src_vec (src_vec),
        .sel     (src_sel),
        .pulse   (sel_pulse)
    );

    frg_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .cfg     (cfg),
        .touched (touched)
    );

    frg_phase_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .pulse    (sel_pulse),
        .sel      (src_sel),
        .cfg      (cfg),
        .clr      (touched),
        .step     (step),
        .drop_eff (drop_eff),
        .phase    (phase_q)
    );

    frg_tick_out #(.CNT_W(CNT_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .tick  (tick_out),
        .count (tick_count),
        .err   (cfg_err)
    );
endmodule

// File: rtl/frg_checker.sv
module frg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             src_osc_en,
    input logic             src_main_en,
    input logic             src_pll_en,
    input logic [1:0]       src_sel,
    input logic             tick_out,
    input logic [CNT_W-1:0] tick_count,
    input logic             cfg_err,
    input logic             drop_eff,
    input logic [8:0]       phase,
    input logic [7:0]       mult,
    input logic [7:0]       div
);
    logic sel_pulse;

    always_comb begin
        case (src_sel)
            2'd0:    sel_pulse = src_osc_en;
            2'd1:    sel_pulse = src_main_en;
            2'd2:    sel_pulse = src_pll_en;
            default: sel_pulse = 1'b0;
        endcase
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!tick_out && tick_count == '0 && !cfg_err));

    assert_tick_has_source_R4: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> $past(sel_pulse));

    assert_mult_zero_passes_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_pulse && !drop_eff && mult == 8'd0) |=> tick_out);

    assert_passthrough_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_pulse && !drop_eff && div != 8'hFF) |=> tick_out);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> $past(sel_pulse && div != 8'hFF));

    assert_phase_bound_R5: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, phase} < (10'd256 + {2'b00, mult})));

    assert_switch_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_pulse && src_sel != $past(src_sel)) |=> !tick_out);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        (tick_count != $past(tick_count)) |-> (tick_out && tick_count == $past(tick_count) + 1'b1));
endmodule

bind frac_rate_gen frg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .src_osc_en  (src_osc_en),
    .src_main_en (src_main_en),
    .src_pll_en  (src_pll_en),
    .src_sel     (src_sel),
    .tick_out    (tick_out),
    .tick_count  (tick_count),
    .cfg_err     (cfg_err),
    .drop_eff    (drop_eff),
    .phase       (phase_q),
    .mult        (cur_mult),
    .div         (cur_div)
);

// File: tb/tb_frac_rate_gen.sv
module tb_frac_rate_gen;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             src_osc_en = 1'b0, src_main_en = 1'b0, src_pll_en = 1'b0;
    logic [1:0]       src_sel = 2'd0;
    logic             cfg_wr = 1'b0, cfg_addr = 1'b0;
    logic [7:0]       cfg_wdata = 8'd0;
    logic [7:0]       cfg_rdata;
    logic             tick_out;
    logic [CNT_W-1:0] tick_count;
    logic             cfg_err;

    frac_rate_gen #(.CNT_W(CNT_W)) dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        bit    tick;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    int   cur_sel = 0;
    int   m_mult, m_div, m_k, m_prev_sel, exp_count;
    bit   m_drop, exp_err;
    bit   done = 0;

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // scoreboard monitor: one expected tick per driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, int'(tick_out), int'(e.tick));
            end
        end
    end

    // driver: one clock of stimulus, expectation pushed from the requirement model
    task automatic step(input bit [2:0] pv, input bit wr, input bit addr,
                        input logic [7:0] data, input string tag);
        bit selp, t;
        int d;
        @(negedge clk);
        {src_pll_en, src_main_en, src_osc_en} = pv;
        src_sel   = 2'(cur_sel);
        cfg_wr    = wr;
        cfg_addr  = addr;
        cfg_wdata = data;
        selp = (cur_sel < 3) && pv[cur_sel];
        t = 0;
        if (cur_sel != m_prev_sel) begin
            m_k = 0;
            m_drop = 1;
        end
        m_prev_sel = cur_sel;
        if (selp) begin
            if (m_div != 255) exp_err = 1;
            if (m_drop) begin
                m_drop = 0;
            end else if (m_div != 255) begin
                t = 1;
            end else begin
                m_k++;
                d = 256 + m_mult;
                t = ((m_k * m_mult) / d) == (((m_k - 1) * m_mult) / d);
            end
        end
        if (wr) begin
            if (addr) m_div = data; else m_mult = data;
            m_k = 0;
        end
        if (t) exp_count++;
        q.push_back('{t, tag});
        @(posedge clk);
        #2;
        {src_pll_en, src_main_en, src_osc_en} = 3'b000;
        cfg_wr = 1'b0;
    endtask

    task automatic pulses(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            step(3'b111, 0, 0, 8'd0, tag);
            for (int g = 0; g < gap; g++) step(3'b000, 0, 0, 8'd0, tag);
        end
    endtask

    task automatic write_field(input bit addr, input logic [7:0] data);
        step(3'b000, 1, addr, data, "R8");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cur_sel = 0;
        src_sel = 2'd0;
        repeat (4) @(posedge clk);
        #2;
        rst = 1'b0;
        m_mult = 0; m_div = 0; m_k = 0; m_prev_sel = 0;
        m_drop = 0; exp_count = 0; exp_err = 0;
    endtask

    task automatic window(input int m);
        int c0;
        write_field(0, 8'(m));
        c0 = int'(tick_count);
        pulses(256 + m, 0, "R4");
        step(3'b000, 0, 0, 8'd0, "R5");
        check("R5 ticks per window", int'(tick_count) - c0, 256);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 tick_out", int'(tick_out), 0);
        check("R1 tick_count", int'(tick_count), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        cfg_addr = 1'b0; #1;
        check("R1 mult reads 0", int'(cfg_rdata), 0);
        cfg_addr = 1'b1; #1;
        check("R1 div reads 0", int'(cfg_rdata), 0);

        write_field(1, 8'hFF);
        write_field(0, 8'h00);
        cfg_addr = 1'b1; #1;
        check("R11 div readback", int'(cfg_rdata), 255);
        cfg_addr = 1'b0; #1;
        check("R11 mult readback", int'(cfg_rdata), 0);

        // R3 full rate pass
        pulses(20, 0, "R3");
        pulses(10, 1, "R3");
        // R2 unselected inputs ignored
        for (int i = 0; i < 8; i++) step(3'b110, 0, 0, 8'd0, "R2");
        check("R2 count after unselected pulses", int'(tick_count), exp_count);

        // R4/R5 swallowing at several ratios
        window(1);
        window(255);
        window(100);
        write_field(0, 8'd37);
        pulses(120, 2, "R4");

        // R8 write restarts phase
        write_field(0, 8'd200);
        pulses(5, 0, "R8");
        write_field(0, 8'd200);
        pulses(30, 0, "R8");
        write_field(1, 8'hFF);
        pulses(12, 1, "R8");

        // R9 source change drops first pulse
        cur_sel = 1;
        step(3'b000, 0, 0, 8'd0, "R9");
        pulses(15, 0, "R9");
        cur_sel = 2;
        pulses(15, 1, "R9");
        cur_sel = 0;
        pulses(3, 0, "R9");
        cur_sel = 3;
        for (int i = 0; i < 10; i++) step(3'b111, 0, 0, 8'd0, "R2");
        cur_sel = 0;
        pulses(6, 0, "R9");

        // R10 counter tracks ticks
        check("R10 tick_count", int'(tick_count), exp_count % (1 << CNT_W));
        check("R7 err clear while supported", int'(cfg_err), 0);

        // R6/R7 unsupported denominator field
        write_field(1, 8'h10);
        check("R7 no err before pulse", int'(cfg_err), 0);
        pulses(40, 0, "R6");
        check("R7 err raised", int'(cfg_err), int'(exp_err));
        write_field(1, 8'hFF);
        pulses(10, 0, "R4");
        check("R7 err sticky", int'(cfg_err), 1);
        check("R10 tick_count final", int'(tick_count), exp_count % (1 << CNT_W));

        do_reset();
        check("R1 err cleared by reset", int'(cfg_err), 0);
        check("R1 count cleared by reset", int'(tick_count), 0);

        repeat (3) @(posedge clk);
        #2;
        check("R4 scoreboard drained", q.size(), 0);
        done = 1;
        summary();
    end
endmodule